// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Alignment Searcher

This block runs on an E1 receive path that already holds basic-frame alignment. Each received frame produces one strobe. With that strobe the block is given the first bit of timeslot 0 and a flag that marks the frame as a non-FAS (odd) frame. The block gathers the bits of the non-FAS frames into an 8-bit word and looks for the 6-bit CRC-4 multiframe sync sequence 001011. The last two bits of the word are the remote error bits, and their value does not matter for the match.

A 2-bit criteria select chooses how many matches must be seen before lock is declared: one, two or three. When more than one is needed, each later match must fall on the same phase modulo 16 frames as the first, so matches are whole multiples of 2 ms apart, and all of them must arrive within a 64-frame (8 ms) window. Once locked, the block gives a free-running frame index within the multiframe and the remote error bits taken from the locking word. Lock holds until the frame-alignment input falls, the select changes, or reset is applied.

Top module: `e1_crc_mf_search`

## Requirements
- R1: With `crit_sel` = 00 no search runs, and `mf_lock` is low one cycle later and stays low.
- R2: Timeslot-0 bits are shifted in only on strobes that have `nfas_frm` = 1. The oldest of the last eight bits is bit 7 of the word, and the word is cleared to zero by reset. A match needs word bits 7..2 = 001011. Bits 1..0 (E1, E2) do not matter, and a single wrong sync bit means no match.
- R3: With `crit_sel` = 01, `mf_lock` rises in the cycle after the strobe that completes the first matching word.
- R4: With `crit_sel` = 10, lock is declared on the second match that lands on the candidate phase, which is 16 frames after the first.
- R5: With `crit_sel` = 11, lock is declared on the third match that lands on the candidate phase.
- R6: While a candidate is pending, a match at any other phase modulo 16 is ignored.
- R7: If lock has not been reached by the 64th strobe after the first match, the candidate is dropped. A match on that same strobe opens a new candidate with a count of one.
- R8: The strobe that declares lock sets `mf_idx` to 15. Each later strobe while locked adds one to it, modulo 16.
- R9: At lock, `rei_bits` takes the value {E1, E2} of the locking word and holds it for as long as lock lasts.
- R10: A falling `fas_ok`, or any change of `crit_sel`, clears lock in the next cycle. While unlocked, `mf_idx` and `rei_bits` read zero.
- R11: While `fas_ok` is low, no candidate is built and lock is not declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle strobe, once per received frame |
| nfas_frm | input | 1 | The current frame is a non-FAS frame |
| ts0_bit | input | 1 | First bit of timeslot 0 of the current frame |
| fas_ok | input | 1 | Basic-frame alignment is held upstream |
| crit_sel | input | 2 | Lock criteria: 00 off, 01/10/11 need 1/2/3 matches |
| mf_lock | output | 1 | Multiframe lock |
| mf_idx | output | 4 | Frame index within the multiframe while locked |
| rei_bits | output | 2 | {E1, E2} captured at lock |

## Verification
Every result passes through one register. `mf_lock`, `mf_idx` and `rei_bits` change in the cycle after the strobe edge that causes the change, and a falling `fas_ok` or a change of select shows in the cycle after the edge that sees it. The bench drives inputs and samples outputs on the falling clock edge, so each comparison sees the state that follows the rising edge just before it. Its behavioural model runs on the same rising edge and is compared every cycle. Each scenario check is made only after the frame that completes a word has been fully clocked.

// File: rtl/e1_mfa_pkg.sv
package e1_mfa_pkg;

  typedef enum logic [1:0] {
    CRIT_OFF   = 2'b00,
    CRIT_ONE   = 2'b01,
    CRIT_TWO   = 2'b10,
    CRIT_THREE = 2'b11
  } crit_e;

  localparam int SYNC_W = 6;
  localparam logic [SYNC_W-1:0] SYNC_SEQ = 6'b001011;
  localparam int WORD_W = 8;
  localparam int EBIT_W = WORD_W - SYNC_W;

  // matches needed for lock; zero when the search is off
  function automatic logic [1:0] need_count(input logic [1:0] sel);
    return sel;
  endfunction

endpackage

// File: rtl/e1_mfa_word_det.sv
module e1_mfa_word_det
  import e1_mfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_stb,
  input  logic              nfas_frm,
  input  logic              ts0_bit,
  output logic              hit,
  output logic [EBIT_W-1:0] ebits
);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_nxt;
  logic              shift_en;

  assign shift_en = frm_stb & nfas_frm;
  assign word_nxt = {word_q[WORD_W-2:0], ts0_bit};

  always_ff @(posedge clk) begin
    if (rst)
      word_q <= '0;
    else if (shift_en)
      word_q <= word_nxt;
  end

  // the match looks at the word including the bit of this frame
  assign hit   = shift_en && (word_nxt[WORD_W-1:EBIT_W] == SYNC_SEQ);
  assign ebits = word_nxt[EBIT_W-1:0];

endmodule

// File: rtl/e1_mfa_tracker.sv
module e1_mfa_tracker
  import e1_mfa_pkg::*;
#(
  parameter int MF_LEN  = 16,
  parameter int WIN_LEN = 64,
  localparam int IDX_W  = $clog2(MF_LEN),
  localparam int AGE_W  = $clog2(WIN_LEN)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_stb,
  input  logic              fas_ok,
  input  logic [1:0]        crit_sel,
  input  logic              hit,
  input  logic [EBIT_W-1:0] ebits,
  output logic              mf_lock,
  output logic [IDX_W-1:0]  mf_idx,
  output logic [EBIT_W-1:0] rei_bits
);

  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(WIN_LEN - 1);

  logic [IDX_W-1:0] fcnt;
  logic             fas_q;
  logic [1:0]       sel_q;
  logic [1:0]       cand_n, n_nxt;
  logic [IDX_W-1:0] cand_ph, ph_nxt;
  logic [AGE_W-1:0] age, age_nxt;
  logic             drop, searching, expired, lock_now;

  assign drop      = (fas_q & ~fas_ok) | (crit_sel != sel_q);
  assign searching = fas_ok && (crit_sel != CRIT_OFF);
  assign expired   = (cand_n != 2'd0) && (age == AGE_LAST);

  always_comb begin
    n_nxt   = cand_n;
    ph_nxt  = cand_ph;
    age_nxt = age;
    if (cand_n == 2'd0 || expired) begin
      age_nxt = '0;
      if (hit) begin
        n_nxt  = 2'd1;
        ph_nxt = fcnt;
      end else begin
        n_nxt  = 2'd0;
      end
    end else begin
      age_nxt = age + 1'b1;
      if (hit && fcnt == cand_ph)
        n_nxt = cand_n + 2'd1;
    end
  end

  assign lock_now = (n_nxt != 2'd0) && (n_nxt >= need_count(crit_sel));

  // frame counter and edge-detect history
  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt  <= '0;
      fas_q <= 1'b0;
      sel_q <= CRIT_OFF;
    end else begin
      fas_q <= fas_ok;
      sel_q <= crit_sel;
      if (frm_stb)
        fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || drop) begin
      mf_lock  <= 1'b0;
      mf_idx   <= '0;
      rei_bits <= '0;
      cand_n   <= 2'd0;
      cand_ph  <= '0;
      age      <= '0;
    end else if (mf_lock) begin
      if (frm_stb)
        mf_idx <= mf_idx + 1'b1;
    end else if (!searching) begin
      cand_n <= 2'd0;
      age    <= '0;
    end else if (frm_stb) begin
      if (lock_now) begin
        mf_lock  <= 1'b1;
        mf_idx   <= '1;
        rei_bits <= ebits;
        cand_n   <= 2'd0;
        age      <= '0;
      end else begin
        cand_n  <= n_nxt;
        cand_ph <= ph_nxt;
        age     <= age_nxt;
      end
    end
  end

endmodule

// File: rtl/e1_crc_mf_search.sv
module e1_crc_mf_search
  import e1_mfa_pkg::*;
#(
  parameter int MF_LEN  = 16,
  parameter int WIN_LEN = 64,
  localparam int IDX_W  = $clog2(MF_LEN)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_stb,
  input  logic             nfas_frm,
  input  logic             ts0_bit,
  input  logic             fas_ok,
  input  logic [1:0]       crit_sel,
  output logic             mf_lock,
  output logic [IDX_W-1:0] mf_idx,
  output logic [1:0]       rei_bits
);

  logic              hit;
  logic [EBIT_W-1:0] ebits;

  e1_mfa_word_det i_det (
    .clk      (clk),
    .rst      (rst),
    .frm_stb  (frm_stb),
    .nfas_frm (nfas_frm),
    .ts0_bit  (ts0_bit),
    .hit      (hit),
    .ebits    (ebits)
  );

  e1_mfa_tracker #(
    .MF_LEN  (MF_LEN),
    .WIN_LEN (WIN_LEN)
  ) i_trk (
    .clk      (clk),
    .rst      (rst),
    .frm_stb  (frm_stb),
    .fas_ok   (fas_ok),
    .crit_sel (crit_sel),
    .hit      (hit),
    .ebits    (ebits),
    .mf_lock  (mf_lock),
    .mf_idx   (mf_idx),
    .rei_bits (rei_bits)
  );

endmodule

// File: rtl/e1_crc_mf_search_chk.sv
module e1_crc_mf_search_chk #(
  parameter int IDX_W = 4
)(
  input logic             clk,
  input logic             rst,
  input logic             frm_stb,
  input logic             fas_ok,
  input logic [1:0]       crit_sel,
  input logic             mf_lock,
  input logic [IDX_W-1:0] mf_idx,
  input logic [1:0]       rei_bits
);

  AST_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (crit_sel == 2'b00) |=> !mf_lock); // R1

  AST_LOCK_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_lock) |-> $past(frm_stb)); // R3

  AST_LOCK_IDX_TOP: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_lock) |-> (mf_idx == {IDX_W{1'b1}})); // R8

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (mf_lock && frm_stb && fas_ok && crit_sel == $past(crit_sel))
      |=> (mf_idx == IDX_W'($past(mf_idx) + 1'b1))); // R8

  AST_REI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mf_lock && $past(mf_lock)) |-> $stable(rei_bits)); // R9

  AST_FAS_FALL_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    $fell(fas_ok) |=> !mf_lock); // R10

  AST_SEL_CHANGE_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    !$stable(crit_sel) |=> !mf_lock); // R10

  AST_NO_SEARCH_WITHOUT_FAS: assert property (@(posedge clk) disable iff (rst)
    (!fas_ok && !mf_lock) |=> !mf_lock); // R11

endmodule

bind e1_crc_mf_search e1_crc_mf_search_chk #(.IDX_W(IDX_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .frm_stb  (frm_stb),
  .fas_ok   (fas_ok),
  .crit_sel (crit_sel),
  .mf_lock  (mf_lock),
  .mf_idx   (mf_idx),
  .rei_bits (rei_bits)
);

// File: tb/test_e1_crc_mf_search.sv
`timescale 1ns/1ps
module test_e1_crc_mf_search;

  localparam logic [5:0] SYNC_SEQ = 6'b001011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_stb = 1'b0;
  logic       nfas_frm = 1'b0;
  logic       ts0_bit = 1'b0;
  logic       fas_ok = 1'b0;
  logic [1:0] crit_sel = 2'b00;
  logic       mf_lock;
  logic [3:0] mf_idx;
  logic [1:0] rei_bits;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  e1_crc_mf_search i_e1_crc_mf_search (
    .clk(clk), .rst(rst), .frm_stb(frm_stb), .nfas_frm(nfas_frm),
    .ts0_bit(ts0_bit), .fas_ok(fas_ok), .crit_sel(crit_sel),
    .mf_lock(mf_lock), .mf_idx(mf_idx), .rei_bits(rei_bits)
  );

  // ---------------- behavioural reference model ----------------
  bit     hist[$];
  int     m_frame, m_cnt, m_phase, m_age, m_idx;
  bit     m_lock;
  bit [1:0] m_rei, m_sel_prev;
  bit     m_fas_prev;

  always @(posedge clk) begin
    bit match, lose;
    int need, newcnt, newph, newage;
    if (rst) begin
      hist = {};
      for (int i = 0; i < 8; i++) hist.push_back(1'b0);
      m_frame = 0; m_cnt = 0; m_phase = 0; m_age = 0; m_idx = 0;
      m_lock = 0; m_rei = 0; m_fas_prev = 0; m_sel_prev = 0;
    end else begin
      lose  = (m_fas_prev && !fas_ok) || (crit_sel != m_sel_prev);
      match = 0;
      if (frm_stb && nfas_frm) begin
        hist.push_back(ts0_bit);
        void'(hist.pop_front());
        match = 1;
        for (int i = 0; i < 6; i++)
          if (hist[i] != SYNC_SEQ[5-i]) match = 0;
      end
      if (lose) begin
        m_lock = 0; m_cnt = 0; m_age = 0; m_idx = 0; m_rei = 0;
      end else if (m_lock) begin
        if (frm_stb) m_idx = (m_idx + 1) % 16;
      end else if (!fas_ok || crit_sel == 2'b00) begin
        m_cnt = 0; m_age = 0;
      end else if (frm_stb) begin
        need = crit_sel;
        newph = m_phase; newage = 0;
        if (m_cnt == 0 || m_age == 63) begin
          newcnt = match ? 1 : 0;
          if (match) newph = m_frame;
        end else begin
          newage = m_age + 1;
          newcnt = (match && m_frame == m_phase) ? m_cnt + 1 : m_cnt;
        end
        if (newcnt >= need && newcnt > 0) begin
          m_lock = 1; m_idx = 15; m_rei = {hist[6], hist[7]};
          m_cnt = 0; m_age = 0;
        end else begin
          m_cnt = newcnt; m_phase = newph; m_age = newage;
        end
      end
      if (frm_stb) m_frame = (m_frame + 1) % 16;
      m_fas_prev = fas_ok;
      m_sel_prev = crit_sel;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 mf_lock vs model", mf_lock, m_lock);
      check("R8 mf_idx vs model", mf_idx, m_idx);
      check("R9 rei_bits vs model", rei_bits, m_rei);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_frame(input int t, input bit good, input bit [1:0] e, input int bad_t);
    bit b;
    if (t % 2 == 0)         b = 1'($urandom);
    else if (!good)         b = 1'b1;
    else if (t <= 11)       b = SYNC_SEQ[5 - (t - 1) / 2];
    else if (t == 13)       b = e[1];
    else                    b = e[0];
    if (t == bad_t) b = ~b;
    @(negedge clk);
    frm_stb = 1'b1; nfas_frm = 1'(t % 2); ts0_bit = b;
    @(negedge clk);
    frm_stb = 1'b0; nfas_frm = 1'b0; ts0_bit = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_mf(input bit good, input bit [1:0] e, input int bad_t);
    for (int t = 0; t < 16; t++) send_frame(t, good, e, bad_t);
  endtask

  task automatic send_fill(input int n);
    for (int t = 0; t < n; t++) send_frame(t, 1'b0, 2'b00, -1);
  endtask

  task automatic restart(input bit [1:0] sel, input bit fas);
    @(negedge clk);
    rst = 1'b1; crit_sel = sel; fas_ok = fas;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // reset state
    restart(2'b01, 1'b1);
    check("R10 reset lock", mf_lock, 0);
    check("R10 reset idx", mf_idx, 0);
    check("R10 reset rei", rei_bits, 0);

    // R1: select off never locks
    restart(2'b00, 1'b1);
    repeat (3) send_mf(1'b1, 2'b11, -1);
    check("R1 off no lock", mf_lock, 0);

    // R2: one wrong sync bit gives no match
    restart(2'b01, 1'b1);
    send_mf(1'b1, 2'b00, 5);
    check("R2 corrupted word", mf_lock, 0);

    // R3/R8/R9: single word lock
    restart(2'b01, 1'b1);
    send_mf(1'b0, 2'b00, -1);
    check("R3 no lock before word", mf_lock, 0);
    send_mf(1'b1, 2'b10, -1);
    check("R3 lock after one word", mf_lock, 1);
    check("R8 idx at lock", mf_idx, 15);
    check("R9 rei at lock", rei_bits, 2);
    send_fill(3);
    check("R8 idx after 3 frames", mf_idx, 2);
    check("R9 rei held", rei_bits, 2);
    @(negedge clk); fas_ok = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 fas fall unlock", mf_lock, 0);
    check("R10 idx zero unlocked", mf_idx, 0);

    // R2: E bits are don't care
    restart(2'b01, 1'b1);
    send_mf(1'b1, 2'b01, -1);
    check("R2 E bits ignored", mf_lock, 1);
    check("R9 rei 01", rei_bits, 1);
    @(negedge clk); crit_sel = 2'b10;
    @(negedge clk); @(negedge clk);
    check("R10 select change unlock", mf_lock, 0);

    // R4: two words
    restart(2'b10, 1'b1);
    send_mf(1'b1, 2'b00, -1);
    check("R4 one word not enough", mf_lock, 0);
    send_mf(1'b1, 2'b11, -1);
    check("R4 lock after two", mf_lock, 1);
    check("R9 rei from second word", rei_bits, 3);

    // R5: three words
    restart(2'b11, 1'b1);
    send_mf(1'b1, 2'b00, -1);
    send_mf(1'b1, 2'b00, -1);
    check("R5 two not enough", mf_lock, 0);
    send_mf(1'b1, 2'b00, -1);
    check("R5 lock after three", mf_lock, 1);

    // R6: wrong phase ignored, then R7 window restart
    restart(2'b10, 1'b1);
    send_mf(1'b1, 2'b00, -1);
    send_fill(8);
    repeat (3) send_mf(1'b1, 2'b00, -1);
    check("R6 wrong phase rejected", mf_lock, 0);
    send_mf(1'b1, 2'b00, -1);
    check("R7 restart needs second", mf_lock, 0);
    send_mf(1'b1, 2'b00, -1);
    check("R7 lock in new window", mf_lock, 1);

    // R7: expiry at the 64th strobe restarts the count
    restart(2'b11, 1'b1);
    send_mf(1'b1, 2'b00, -1);
    send_mf(1'b1, 2'b00, -1);
    send_mf(1'b0, 2'b00, -1);
    send_mf(1'b0, 2'b00, -1);
    send_mf(1'b1, 2'b00, -1);
    send_mf(1'b1, 2'b00, -1);
    check("R7 expired candidate dropped", mf_lock, 0);
    send_mf(1'b1, 2'b00, -1);
    check("R7 lock after fresh three", mf_lock, 1);

    // R11: no search without frame alignment
    restart(2'b01, 1'b0);
    repeat (2) send_mf(1'b1, 2'b00, -1);
    check("R11 no lock without fas", mf_lock, 0);
    @(negedge clk); fas_ok = 1'b1;
    send_mf(1'b1, 2'b00, -1);
    check("R11 lock once fas returns", mf_lock, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule